// File: doc/BRIEF.md
# Floating-Point Special-Case Bypass Unit

This block looks at the two single-precision operands of an adder before any arithmetic happens. It works out whether their sum can be given without using the adder at all. The sum needs no arithmetic when one operand is a zero, an infinity or a NaN. In those cases the block drives the finished result on its own 32-bit output and holds the adder-enable flag low. When both operands are finite nonzero values, normal or subnormal, the flag goes high. The downstream alignment, add and normalise path then takes over, and the bypass result is not used.

The block is purely combinational. Each operand is split into a sign (most significant bit), an 8-bit biased exponent and a 23-bit fraction. Each operand is then classified as zero, subnormal, normal, infinity or NaN. A fixed priority then picks the result: NaN first, then infinity, then zero. All widths are parameters. The default values describe the single-precision format.

Top module: `fpSpecialBypass`

## Requirements
- R1: Each operand is classified from its fields as follows. The sign is bit 31, the exponent is bits 30..23 and the fraction is bits 22..0.
  - Exponent 0 with fraction 0 is zero.
  - Exponent 0 with a nonzero fraction is subnormal.
  - Exponent 255 with fraction 0 is infinity.
  - Exponent 255 with a nonzero fraction is NaN.
  - Any other exponent is normal.
- R2: If A is zero and B is not NaN or infinity, the result equals B bit for bit, including its sign.
- R3: If B is zero and A is not NaN or infinity, the result equals A bit for bit, including its sign.
- R4: A finite A with an infinite B gives B, which is infinity with B's sign. An infinite A with a finite B gives A.
- R5: Two infinities of the same sign give infinity with that sign.
- R6: Two infinities of opposite sign give the NaN word 0xFFC00000.
- R7: If either operand is NaN, the result is 0xFFC00000, whatever the other operand is.
- R8: The enable flag is 1 exactly when both operands are normal or subnormal. In that case the result word is driven to 0.
- R9: When both operands are zero, of either sign, the result is operand B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 32 | First operand, single-precision word |
| opB | input | 32 | Second operand, single-precision word |
| sumOut | output | 32 | Direct result; meaningful while adderEn is 0 |
| adderEn | output | 1 | 1 when the arithmetic datapath must compute the sum |

## Verification
The embedded assertions are checked on every evaluation of the logic. They confirm the following:
- At most one result source is selected.
- The enable flag never coexists with a bypass selection.
- A NaN on either input always yields the fixed NaN word.
- The enable flag tracks the finite-nonzero classification of both operands.

Only the bench scenarios can show the following:
- That the exact sign of a passed-through zero or infinity is preserved.
- That the double-zero case picks B.
- That NaN beats infinity and zero in priority.

To show these, the bench compares directed corner pairs and biased random pairs against an independent behavioural model.

// File: rtl/fpbyp_pkg.sv
package fpbyp_pkg;

  // classification of one operand
  typedef struct packed {
    logic sign;
    logic isZero;
    logic isSub;
    logic isNorm;
    logic isInf;
    logic isNan;
  } opClass_t;

  // strobes from control to datapath
  typedef struct packed {
    logic pickA;
    logic pickB;
    logic pickNan;
    logic runAdder;
  } bypStrobe_t;

endpackage

// File: rtl/fpOperandClass.sv
module fpOperandClass
  import fpbyp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] word,
  output opClass_t              cls
);
  localparam int WORD_W = 1 + EXP_W + FRAC_W;

  logic [EXP_W-1:0]  expField;
  logic [FRAC_W-1:0] fracField;
  logic expMin;
  logic expMax;
  logic fracNz;

  always_comb begin
    expField  = word[WORD_W-2 -: EXP_W];
    fracField = word[FRAC_W-1:0];
    expMin    = (expField == '0);
    expMax    = (expField == '1);
    fracNz    = |fracField;

    cls.sign   = word[WORD_W-1];
    cls.isZero = expMin & ~fracNz;
    cls.isSub  = expMin &  fracNz;
    cls.isInf  = expMax & ~fracNz;
    cls.isNan  = expMax &  fracNz;
    cls.isNorm = ~expMin & ~expMax;
  end

  // R1: exactly one class is active for any word
  always_comb begin
    a_r1_one_class: assert ($countones({cls.isZero, cls.isSub, cls.isNorm,
                                        cls.isInf, cls.isNan}) == 1)
      else $error("operand class not unique");
  end

endmodule

// File: rtl/fpBypassCtrl.sv
module fpBypassCtrl
  import fpbyp_pkg::*;
(
  input  opClass_t   clsA,
  input  opClass_t   clsB,
  output bypStrobe_t strobe
);
  logic anyNan;
  logic infClash;
  logic finiteA;
  logic finiteB;

  always_comb begin
    anyNan   = clsA.isNan | clsB.isNan;
    infClash = clsA.isInf & clsB.isInf & (clsA.sign ^ clsB.sign);
    finiteA  = clsA.isNorm | clsA.isSub;
    finiteB  = clsB.isNorm | clsB.isSub;

    strobe = '0;
    if (anyNan || infClash) begin
      strobe.pickNan = 1'b1;            // R6, R7
    end else if (clsA.isInf) begin
      strobe.pickA = 1'b1;              // R4, R5
    end else if (clsB.isInf) begin
      strobe.pickB = 1'b1;              // R4
    end else if (clsA.isZero) begin
      strobe.pickB = 1'b1;              // R2, R9
    end else if (clsB.isZero) begin
      strobe.pickA = 1'b1;              // R3
    end else begin
      strobe.runAdder = 1'b1;           // R8
    end
  end

  // R8: adder runs exactly when both operands are finite and nonzero
  always_comb begin
    a_r8_run_iff_finite: assert (strobe.runAdder == (finiteA & finiteB))
      else $error("adder enable mismatch");
    a_r8_single_source: assert ($onehot0({strobe.pickA, strobe.pickB,
                                          strobe.pickNan, strobe.runAdder}))
      else $error("more than one source selected");
  end

endmodule

// File: rtl/fpBypassData.sv
module fpBypassData
  import fpbyp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] wordA,
  input  logic [EXP_W+FRAC_W:0] wordB,
  input  bypStrobe_t            strobe,
  output logic [EXP_W+FRAC_W:0] result,
  output logic                  enable
);
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam logic [WORD_W-1:0] NAN_WORD =
    {1'b1, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  always_comb begin
    unique case (1'b1)
      strobe.pickNan: result = NAN_WORD;
      strobe.pickA:   result = wordA;
      strobe.pickB:   result = wordB;
      default:        result = '0;
    endcase
    enable = strobe.runAdder;
  end

  // R8: an enabled adder never sees a bypass word
  always_comb begin
    a_r8_quiet_when_enabled: assert (!enable || result == '0)
      else $error("result not cleared while enabled");
  end

endmodule

// File: rtl/fpSpecialBypass.sv
module fpSpecialBypass
  import fpbyp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] opA,
  input  logic [EXP_W+FRAC_W:0] opB,
  output logic [EXP_W+FRAC_W:0] sumOut,
  output logic                  adderEn
);
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam logic [WORD_W-1:0] NAN_WORD =
    {1'b1, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic [WORD_W-1:0] opWord [2];
  opClass_t          opCls  [2];
  bypStrobe_t        strobe;

  always_comb begin
    opWord[0] = opA;
    opWord[1] = opB;
  end

  for (genvar i = 0; i < 2; i++) begin : g_class
    fpOperandClass #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .word (opWord[i]),
      .cls  (opCls[i])
    );
  end

  fpBypassCtrl u_ctrl (
    .clsA   (opCls[0]),
    .clsB   (opCls[1]),
    .strobe (strobe)
  );

  fpBypassData #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_data (
    .wordA  (opA),
    .wordB  (opB),
    .strobe (strobe),
    .result (sumOut),
    .enable (adderEn)
  );

  // R7: a NaN operand always produces the fixed NaN word
  always_comb begin
    a_r7_nan_wins: assert (!(opCls[0].isNan || opCls[1].isNan) ||
                           (sumOut == NAN_WORD && !adderEn))
      else $error("NaN operand not forced to NaN result");
  end

endmodule

// File: tb/fpSpecialBypass_test.sv
module fpSpecialBypass_test;

  logic        clk = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [31:0] sumOut;
  logic        adderEn;
  int          total = 0;
  int          bad = 0;
  bit          done = 0;

  localparam logic [31:0] QNAN = 32'hFFC0_0000;

  always #5 clk = ~clk;

  fpSpecialBypass uut (
    .opA     (opA),
    .opB     (opB),
    .sumOut  (sumOut),
    .adderEn (adderEn)
  );

  // behavioural classes: 0 zero, 1 finite, 2 inf, 3 nan
  function automatic int kindOf(input logic [31:0] w);
    int e = int'(w[30:23]);
    int f = int'(w[22:0]);
    if (e == 0)   return (f == 0) ? 0 : 1;
    if (e == 255) return (f == 0) ? 2 : 3;
    return 1;
  endfunction

  function automatic logic [32:0] model(input logic [31:0] a, input logic [31:0] b);
    int ka = kindOf(a);
    int kb = kindOf(b);
    if (ka == 3 || kb == 3) return {1'b0, QNAN};
    if (ka == 2 && kb == 2) return (a[31] == b[31]) ? {1'b0, a} : {1'b0, QNAN};
    if (ka == 2) return {1'b0, a};
    if (kb == 2) return {1'b0, b};
    if (ka == 0) return {1'b0, b};
    if (kb == 0) return {1'b0, a};
    return {1'b1, 32'h0};
  endfunction

  function automatic string tagOf(input logic [31:0] a, input logic [31:0] b);
    int ka = kindOf(a);
    int kb = kindOf(b);
    if (ka == 3 || kb == 3) return "R7";
    if (ka == 2 && kb == 2) return (a[31] == b[31]) ? "R5" : "R6";
    if (ka == 2 || kb == 2) return "R4";
    if (ka == 0 && kb == 0) return "R9";
    if (ka == 0) return "R2";
    if (kb == 0) return "R3";
    return "R8";
  endfunction

  // drive on posedge, compare on the following negedge
  task automatic apply(input logic [31:0] a, input logic [31:0] b, input string tag);
    logic [32:0] exp;
    @(posedge clk);
    opA = a;
    opB = b;
    @(negedge clk);
    exp = model(a, b);
    total++;
    if (adderEn !== exp[32] || sumOut !== exp[31:0]) begin
      bad++;
      $display("FAIL %s a=%h b=%h got en=%0b res=%h exp en=%0b res=%h",
               tag, a, b, adderEn, sumOut, exp[32], exp[31:0]);
    end
  endtask

  function automatic logic [31:0] randWord();
    logic [31:0] w = $urandom;
    case ($urandom % 6)
      0: w[30:0] = '0;
      1: begin w[30:23] = 8'hFF; w[22:0] = '0; end
      2: begin w[30:23] = 8'hFF; w[22] = $urandom % 2; w[0] = 1'b1; end
      3: w[30:23] = 8'h00;
      default: ;
    endcase
    return w;
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // reset-state style check: two zeros at start, R9
    @(negedge clk);
    total++;
    if (adderEn !== 1'b0 || sumOut !== 32'h0) begin
      bad++;
      $display("FAIL R9 initial got en=%0b res=%h exp en=0 res=00000000", adderEn, sumOut);
    end
    apply(32'h0000_0000, 32'h4120_0000, "R2");
    apply(32'h8000_0000, 32'hC000_0001, "R2");
    apply(32'h3F80_0000, 32'h8000_0000, "R3");
    apply(32'h0000_0005, 32'h0000_0000, "R3");
    apply(32'h8000_0000, 32'h0000_0000, "R9");
    apply(32'h0000_0000, 32'h8000_0000, "R9");
    apply(32'h3F80_0000, 32'hFF80_0000, "R4");
    apply(32'h7F80_0000, 32'h0000_0001, "R4");
    apply(32'h0000_0000, 32'hFF80_0000, "R4");
    apply(32'hFF80_0000, 32'hFF80_0000, "R5");
    apply(32'h7F80_0000, 32'h7F80_0000, "R5");
    apply(32'h7F80_0000, 32'hFF80_0000, "R6");
    apply(32'hFF80_0000, 32'h7F80_0000, "R6");
    apply(32'h7FC0_0000, 32'h3F80_0000, "R7");
    apply(32'h0000_0000, 32'h7F80_0001, "R7");
    apply(32'h7F80_0000, 32'hFFFF_FFFF, "R7");
    apply(32'h3F80_0000, 32'h4000_0000, "R8");
    apply(32'h0000_0001, 32'h807F_FFFF, "R8");
    apply(32'h7F7F_FFFF, 32'h0080_0000, "R1");
    apply(32'h0080_0000, 32'h007F_FFFF, "R1");
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a = randWord();
      logic [31:0] b = randWord();
      apply(a, b, tagOf(a, b));
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule